// File: doc/BRIEF.md
# Dual Repeating Down-Counter Timer Block

This block holds a pair of programmable down-counting timers and a free-running microsecond counter, all reached through a simple word-wide register bus. Software programs a timer by writing one configuration word that packs a reload count, a repeat flag, an enable flag and one spare bit. Each enabled timer counts down once per microsecond tick. When it expires, it raises a sticky interrupt flag that drives one line of the `irq` output towards the interrupt controller.

The interrupt is acknowledged implicitly. Reading a timer's present-value register clears that timer's flag, so no separate acknowledge register exists. In repeat mode the timer reloads itself and runs on. In one-shot mode it stops and drops its own enable bit. The microsecond tick arrives as an input enable; dividing it from the clock happens elsewhere. The free-running counter advances on the same tick, and software reads it at its own address.

Bus reads are combinational: `bus_rdata` reflects `bus_addr` in the same cycle. Side effects of a read (flag clearing) and of a write take place at the next rising clock edge.

Top module: `timer_pair`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is all zero.
- R2: A write to timer i's configuration word (byte offset 8*i) stores all 32 bits. Bits 29:0 and the enable bit read back as written. Bit 29 is spare and changes no behaviour.
- R3: A configuration write with bit 31 (enable) set loads the timer's counter from bits 28:0. The counter reads back, zero-extended, at byte offset 8*i+4.
- R4: On each cycle with `us_tick` high while bit 31 is set, the counter decrements. With count N, expiry happens on the Nth tick, and a count of 0 behaves as 1. Without a tick, or while disabled, the counter holds.
- R5: On expiry, timer i's flag sets and drives `irq[i]` (bit 0 for timer 0, bit 1 for timer 1). With bit 30 (repeat) set, the counter reloads from bits 28:0. Otherwise the counter stays at 0 and bit 31 of the configuration word clears.
- R6: A read of timer i's present-value offset clears its flag at the next edge. Reading the configuration word leaves the flag untouched.
- R7: If an expiry and a clearing read of the same timer fall in one cycle, the flag stays set.
- R8: The microsecond counter at offset 8*NUM_TIMERS (0x10 by default) counts up by one on every `us_tick` cycle. It ignores writes.
- R9: A configuration write in the same cycle as a tick takes priority. That tick neither decrements nor expires the timer.
- R10: The two timers act independently. Traffic to one never changes the other's count, configuration or flag.
- R11: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle microsecond tick enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (enables read side effects) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | NUM_TIMERS | Per-timer interrupt flags |

## Verification
The assertions take for granted that `bus_wr` and `bus_rd` are never high together and that `us_tick` is a plain level sampled at each edge. They relate the flags, the read strobe and the tick, and they look at `bus_rdata` only when the same address was held over two cycles. The stimulus meets these conditions: every cycle carries at most one bus operation. The directed phases hold an address steady while ticks run, and the randomised phase chooses reads and writes as exclusive operations with small counts, so that expiries, reloads and read/expiry collisions occur often.

// File: rtl/timer_pair_pkg.sv
// Package: shared field positions and widths of the timer pair.
// Assumes a 32-bit bus word; field positions are fixed by the register layout.
package timer_pair_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 29;
    localparam int EN_BIT    = 31;
    localparam int REP_BIT   = 30;
    localparam int SPARE_BIT = 29;
    localparam int STRIDE    = 8;   // byte spacing of one timer's register pair
    localparam int VAL_OFS   = 4;   // present-value offset within the pair

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/timer_chan.sv
// Module: one down-counting timer channel.
// Holds the configuration word, the live counter and the sticky expiry flag.
// Assumes cfg_we and val_rd are already decoded for this channel and are
// never both high; a configuration write outranks a tick in the same cycle.
module timer_chan
    import timer_pair_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  cfg_we,
    input  word_t wdata,
    input  logic  val_rd,
    output word_t cfg_q,
    output cnt_t  cnt_q,
    output logic  flag_q
);
    logic enabled;
    logic at_end;
    logic expire;

    // Decode the run state and the expiry event for this cycle.
    always_comb begin
        enabled = cfg_q[EN_BIT];
        at_end  = (cnt_q <= cnt_t'(1));
        expire  = !cfg_we && tick && enabled && at_end;
    end

    // Configuration word and counter: write, decrement, reload or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= wdata;
            if (wdata[EN_BIT]) begin
                cnt_q <= wdata[CNT_W-1:0];
            end
        end else if (tick && enabled) begin
            if (at_end) begin
                if (cfg_q[REP_BIT]) begin
                    cnt_q <= cfg_q[CNT_W-1:0];
                end else begin
                    cnt_q         <= '0;
                    cfg_q[EN_BIT] <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - cnt_t'(1);
            end
        end
    end

    // Sticky flag: set on expiry, cleared by a present-value read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (val_rd) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/usec_counter.sv
// Module: free-running microsecond counter.
// Advances by one on each tick-enable cycle and wraps at its width.
// Assumes the tick is already a single-cycle enable in the clk domain.
module usec_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [WIDTH-1:0] count_q
);
    // Count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + WIDTH'(1);
        end
    end
endmodule

// File: rtl/timer_pair.sv
// Module: timer pair top. It decodes the register bus, instantiates one
// timer_chan per timer and the microsecond counter, and muxes read data.
// Map: timer i config at 8*i, present value at 8*i+4, microsecond counter
// at 8*NUM_TIMERS. Assumes bus_wr and bus_rd are exclusive; ADDR_W must
// cover 8*NUM_TIMERS.
module timer_pair
    import timer_pair_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int ADDR_W     = 5,
    parameter int USEC_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);
    localparam logic [ADDR_W-1:0] USEC_ADDR = ADDR_W'(NUM_TIMERS * STRIDE);

    word_t             cfg_w  [NUM_TIMERS];
    cnt_t              cnt_w  [NUM_TIMERS];
    logic [USEC_W-1:0] usec_w;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(i * STRIDE);
        localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(i * STRIDE + VAL_OFS);

        timer_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (us_tick),
            .cfg_we (bus_wr && (bus_addr == CFG_A)),
            .wdata  (bus_wdata),
            .val_rd (bus_rd && (bus_addr == VAL_A)),
            .cfg_q  (cfg_w[i]),
            .cnt_q  (cnt_w[i]),
            .flag_q (irq[i])
        );
    end

    usec_counter #(.WIDTH(USEC_W)) u_usec (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (us_tick),
        .count_q (usec_w)
    );

    // Read multiplexer: select the addressed register, zero when unmapped.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (bus_addr == ADDR_W'(i * STRIDE)) begin
                bus_rdata = cfg_w[i];
            end
            if (bus_addr == ADDR_W'(i * STRIDE + VAL_OFS)) begin
                bus_rdata = DATA_W'(cnt_w[i]);
            end
        end
        if (bus_addr == USEC_ADDR) begin
            bus_rdata = DATA_W'(usec_w);
        end
    end
endmodule

// File: rtl/timer_pair_chk.sv
// Checker: timing properties of the timer pair, seen at its ports.
// Assumes bus_wr and bus_rd are never high together.
module timer_pair_chk
    import timer_pair_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int ADDR_W     = 5,
    parameter int USEC_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  us_tick,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic [NUM_TIMERS-1:0] irq
);
    localparam logic [ADDR_W-1:0] U_A = ADDR_W'(NUM_TIMERS * STRIDE);

    AST_IRQ_RESET: assert property (@(posedge clk) $past(!rst_n) |-> irq == '0); // R1

    AST_USEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bus_addr == U_A && $past(bus_addr == U_A) && !$past(us_tick))
        |-> $stable(bus_rdata)); // R8

    AST_USEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bus_addr == U_A && $past(bus_addr == U_A) && $past(us_tick))
        |-> bus_rdata == $past(bus_rdata) + 32'd1); // R8

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_t
        localparam logic [ADDR_W-1:0] C_A = ADDR_W'(i * STRIDE);
        localparam logic [ADDR_W-1:0] V_A = ADDR_W'(i * STRIDE + VAL_OFS);

        AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(irq[i])) |-> $past(us_tick)); // R5

        AST_IRQ_FALL_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $fell(irq[i])) |-> $past(bus_rd && bus_addr == V_A)); // R6

        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(bus_rd && bus_addr == V_A && !us_tick)) |-> !irq[i]); // R6

        AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && bus_addr == C_A && $past(bus_wr && bus_addr == C_A))
            |-> bus_rdata[SPARE_BIT:0] == $past(bus_wdata[SPARE_BIT:0])); // R2
    end
endmodule

bind timer_pair timer_pair_chk #(
    .NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W), .USEC_W(USEC_W)
) u_chk (.*);

// File: tb/timer_pair_test.sv
`timescale 1ns/100ps
// Bench: a behavioural reference model, stepped once per clock and compared
// against bus_rdata and irq in every cycle, driven by directed and random phases.
module timer_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    logic [31:0] m_cfg  [2];
    logic [31:0] m_cnt  [2];
    logic        m_flag [2];
    logic [31:0] m_usec;

    timer_pair uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", t, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] a);
        if (a == 5'h00) return m_cfg[0];
        if (a == 5'h04) return m_cnt[0];
        if (a == 5'h08) return m_cfg[1];
        if (a == 5'h0C) return m_cnt[1];
        if (a == 5'h10) return m_usec;
        return 32'h0;
    endfunction

    // One clock: drive, compare, then advance the model to the next edge.
    task automatic cyc(input logic wr, input logic rd, input logic [4:0] a,
                       input logic [31:0] wd, input logic tk);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; us_tick = tk;
        #1;
        check({tag, " rdata"}, bus_rdata, model_read(a));
        check({tag, " irq"}, {30'h0, irq}, {30'h0, m_flag[1], m_flag[0]});
        for (int t = 0; t < 2; t++) begin
            bit whit = wr && (a == 5'(8 * t));
            bit rhit = rd && (a == 5'(8 * t + 4));
            bit exp_e = !whit && tk && m_cfg[t][31] && (m_cnt[t] <= 1);
            if (whit) begin
                m_cfg[t] = wd;
                if (wd[31]) m_cnt[t] = {3'b0, wd[28:0]};
            end else if (tk && m_cfg[t][31]) begin
                if (m_cnt[t] <= 1) begin
                    if (m_cfg[t][30]) m_cnt[t] = {3'b0, m_cfg[t][28:0]};
                    else begin m_cnt[t] = 0; m_cfg[t][31] = 1'b0; end
                end else m_cnt[t] = m_cnt[t] - 1;
            end
            if (exp_e) m_flag[t] = 1'b1;
            else if (rhit) m_flag[t] = 1'b0;
        end
        if (tk) m_usec = m_usec + 1;
    endtask

    task automatic idle(input int n, input logic [4:0] a, input logic tk);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, a, 32'h0, tk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < 2; t++) begin m_cfg[t] = 0; m_cnt[t] = 0; m_flag[t] = 0; end
        m_usec = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state on every address
        tag = "R1";
        for (int a = 0; a <= 20; a += 4) cyc(1'b0, 1'b0, 5'(a), 32'h0, 1'b0);
        // R2: spare and count stored, no enable: no countdown
        tag = "R2";
        cyc(1'b1, 1'b0, 5'h00, 32'h2000_0005, 1'b0);
        idle(3, 5'h00, 1'b1);
        idle(2, 5'h04, 1'b1);
        // R3: enable loads counter
        tag = "R3";
        cyc(1'b1, 1'b0, 5'h00, 32'hA000_0004, 1'b0);
        idle(1, 5'h04, 1'b0);
        // R4: decrement only on ticks, expire on 4th
        tag = "R4";
        idle(2, 5'h04, 1'b0);
        idle(2, 5'h04, 1'b1);
        idle(2, 5'h04, 1'b0);
        // R5: one-shot expiry sets irq[0], clears enable
        tag = "R5";
        idle(3, 5'h04, 1'b1);
        idle(2, 5'h00, 1'b1);
        // R6: config read keeps flag, value read clears it
        tag = "R6";
        cyc(1'b0, 1'b1, 5'h00, 32'h0, 1'b0);
        cyc(1'b0, 1'b1, 5'h04, 32'h0, 1'b0);
        idle(2, 5'h04, 1'b0);
        // R5: repeat on timer 1, count 3
        tag = "R5";
        cyc(1'b1, 1'b0, 5'h08, 32'hC000_0003, 1'b0);
        idle(8, 5'h0C, 1'b1);
        // R7: read collides with expiry, flag stays
        tag = "R7";
        cyc(1'b1, 1'b0, 5'h00, 32'hC000_0001, 1'b0);
        cyc(1'b0, 1'b1, 5'h04, 32'h0, 1'b1);
        cyc(1'b0, 1'b1, 5'h04, 32'h0, 1'b1);
        idle(2, 5'h00, 1'b0);
        // R4: count of zero acts as one
        tag = "R4";
        cyc(1'b1, 1'b0, 5'h00, 32'h8000_0000, 1'b0);
        cyc(1'b0, 1'b1, 5'h04, 32'h0, 1'b0);
        idle(3, 5'h04, 1'b1);
        // R8: usec counts ticks, ignores writes
        tag = "R8";
        idle(3, 5'h10, 1'b1);
        cyc(1'b1, 1'b0, 5'h10, 32'h1234_5678, 1'b0);
        idle(2, 5'h10, 1'b0);
        // R9: write with tick wins
        tag = "R9";
        cyc(1'b1, 1'b0, 5'h08, 32'h8000_0002, 1'b1);
        idle(3, 5'h0C, 1'b1);
        // R11: unmapped addresses
        tag = "R11";
        idle(1, 5'h14, 1'b0);
        idle(1, 5'h1C, 1'b1);
        // R10: random mix of both timers
        tag = "R10";
        for (int n = 0; n < 3000; n++) begin
            int op = $urandom_range(0, 3);
            logic [4:0] a = 5'(4 * $urandom_range(0, 5));
            logic [31:0] wd = {$urandom_range(0, 7) > 1 ? 1'b1 : 1'b0,
                               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                               26'h0, 3'($urandom_range(0, 7))};
            logic tk = 1'($urandom_range(0, 1));
            if (op == 1) a = 5'(8 * $urandom_range(0, 1));
            cyc(op == 1 || op == 3, op == 2, a, wd, tk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule